// File: doc/BRIEF.md
# Interrupt Redirection Message Dispatcher

This block converts a request naming one interrupt input line into zero, one or several interrupt delivery messages. When it accepts a request, it reads the redirection entry for that line from an external synchronous table. A read issued in one cycle returns its data in the next. The dispatcher then decides what to do with the entry. A masked entry is dropped without a trace. A physically addressed entry yields exactly one message. A logically addressed entry has its 8-bit destination bitmap expanded into one message per set bit, starting from the lowest bit.

Messages leave through a valid/ready stream. While a message is outstanding or a bitmap is still being walked, the dispatcher does not accept a new request. A request that names a line outside the table raises a one-cycle error pulse and produces nothing. An unmasked entry that carries a reserved delivery-mode code does the same.

Top module: `irq_msg_dispatch`

## Requirements
- R1: If the entry read has its mask bit (bit 14) set, no message and no error are produced, and the block is idle again on the second cycle after the request was accepted.
- R2: The table entry layout is: vector [7:0], delivery mode [10:8], destination mode [11] (0 physical, 1 logical), polarity [12], trigger [13], mask [14], destination [22:15]. Every message copies the vector, delivery mode, destination mode and trigger from the entry, and its level output equals the entry polarity.
- R3: With destination mode 0, exactly one message is sent, and its target equals the 8-bit destination field. A destination of zero is a valid target.
- R4: With destination mode 1, one message is sent for each set bit of the destination bitmap, and its target is that bit's position (0 to 7).
- R5: The messages of a logical expansion leave in strictly ascending target order.
- R6: A request line number equal to or above the table depth (default 24) issues no table read, pulses the error output in the first cycle after acceptance, and sends nothing.
- R7: An unmasked entry whose delivery mode is reserved (codes 3 and 6 by default) pulses the error output on the second cycle after acceptance and sends nothing. A masked entry with a reserved code is dropped silently.
- R8: A message that is valid but not accepted keeps valid high and all its fields unchanged until it is accepted.
- R9: While a message is valid or a bitmap is being expanded, the request ready is low, busy is high, and a pending request is not taken until the last message has been accepted.
- R10: A logical entry with an all-zero bitmap sends nothing and raises no error, and the block is idle again on the second cycle after acceptance.
- R11: After reset, the message valid and error outputs are low, busy is low and the request ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Interrupt request present |
| req_line | input | LINE_W | Interrupt line number |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| tbl_rd_en | output | 1 | Table read strobe |
| tbl_rd_addr | output | ADDR_W | Table read index |
| tbl_rd_data | input | 23 | Entry returned one cycle after the strobe |
| msg_valid | output | 1 | Message valid |
| msg_ready | input | 1 | Message taken by the receiver |
| msg_target | output | 8 | Target ID of the message |
| msg_vector | output | 8 | Interrupt vector |
| msg_dmode | output | 3 | Delivery mode |
| msg_logical | output | 1 | Destination mode carried in the message |
| msg_level | output | 1 | Level, taken from the entry polarity |
| msg_trigger | output | 1 | Trigger mode |
| err_o | output | 1 | One-cycle error pulse |
| busy | output | 1 | Request in progress |

## Verification
The bench walks sparse, single-bit and full bitmaps while the receiver stalls at random. A design that scans from the top, skips a bit next to a stall, or updates the target while stalled would reorder, lose or corrupt messages. Physical destination zero is set against the all-zero logical bitmap: confusing the two would either lose a real message or invent one. The bench holds a second request against a running expansion to expose early intake. It also probes the last legal line, the first illegal line and a masked entry that carries a reserved mode, which exposes an off-by-one range test or a mask check done after the mode check.

// File: rtl/irq_disp_pkg.sv
package irq_disp_pkg;
  localparam int DEST_W = 8;
  localparam int VEC_W  = 8;
  localparam int MODE_W = 3;
  localparam int TGT_IW = $clog2(DEST_W);

  // Redirection entry as delivered by the table (LSB = vector bit 0)
  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              mask;
    logic              trig;
    logic              pol;
    logic              logical;
    logic [MODE_W-1:0] dmode;
    logic [VEC_W-1:0]  vector;
  } rte_t;

  localparam int RTE_W = $bits(rte_t);

  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_SEND} st_t;
  typedef enum logic [2:0] {CL_DROP, CL_ERR, CL_ONE, CL_MAP, CL_EMPTY} cls_t;
endpackage

// File: rtl/irq_lowbit.sv
module irq_lowbit #(
  parameter int W  = 8,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [W-1:0]  low,
  output logic [IW-1:0] idx
);
  always_comb begin
    low = vec & (~vec + 1'b1);
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (low[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irq_rte_classify.sv
module irq_rte_classify
  import irq_disp_pkg::*;
#(
  parameter logic [2**MODE_W-1:0] RSVD_MODES = 8'b0100_1000
) (
  input  rte_t ent,
  output cls_t cls
);
  always_comb begin
    if (ent.mask)                   cls = CL_DROP;
    else if (RSVD_MODES[ent.dmode]) cls = CL_ERR;
    else if (!ent.logical)          cls = CL_ONE;
    else if (ent.dest == '0)        cls = CL_EMPTY;
    else                            cls = CL_MAP;
  end
endmodule

// File: rtl/irq_msg_dispatch.sv
module irq_msg_dispatch
  import irq_disp_pkg::*;
#(
  parameter int TBL_DEPTH = 24,
  parameter int LINE_W    = 5,
  parameter logic [2**MODE_W-1:0] RSVD_MODES = 8'b0100_1000,
  localparam int ADDR_W   = $clog2(TBL_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [LINE_W-1:0] req_line,
  output logic              req_ready,
  output logic              tbl_rd_en,
  output logic [ADDR_W-1:0] tbl_rd_addr,
  input  logic [RTE_W-1:0]  tbl_rd_data,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [DEST_W-1:0] msg_target,
  output logic [VEC_W-1:0]  msg_vector,
  output logic [MODE_W-1:0] msg_dmode,
  output logic              msg_logical,
  output logic              msg_level,
  output logic              msg_trigger,
  output logic              err_o,
  output logic              busy
);
  localparam logic [LINE_W:0] DEPTH_V = (LINE_W+1)'(TBL_DEPTH);

  st_t                st_q;
  rte_t               ent;
  cls_t               cls;
  logic               acc, bad_line;
  logic [DEST_W-1:0]  rem_q, scan_src, scan_low;
  logic [TGT_IW-1:0]  scan_idx;

  assign ent       = rte_t'(tbl_rd_data);
  assign req_ready = (st_q == ST_IDLE);
  assign busy      = (st_q != ST_IDLE);
  assign acc       = req_valid && req_ready;
  assign bad_line  = {1'b0, req_line} >= DEPTH_V;
  assign tbl_rd_en = acc && !bad_line;
  assign tbl_rd_addr = ADDR_W'(req_line);

  // Bitmap source: fresh entry during lookup, leftover bits while sending
  assign scan_src = (st_q == ST_LOOK) ? ent.dest : rem_q;

  irq_lowbit #(.W(DEST_W), .IW(TGT_IW)) u_low (
    .vec (scan_src),
    .low (scan_low),
    .idx (scan_idx)
  );

  irq_rte_classify #(.RSVD_MODES(RSVD_MODES)) u_cls (
    .ent (ent),
    .cls (cls)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      rem_q       <= '0;
      msg_valid   <= 1'b0;
      msg_target  <= '0;
      msg_vector  <= '0;
      msg_dmode   <= '0;
      msg_logical <= 1'b0;
      msg_level   <= 1'b0;
      msg_trigger <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      err_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (acc) begin
            if (bad_line) err_o <= 1'b1;
            else          st_q  <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          msg_vector  <= ent.vector;
          msg_dmode   <= ent.dmode;
          msg_logical <= ent.logical;
          msg_level   <= ent.pol;
          msg_trigger <= ent.trig;
          unique case (cls)
            CL_ERR: begin
              err_o <= 1'b1;
              st_q  <= ST_IDLE;
            end
            CL_ONE: begin
              msg_target <= ent.dest;
              rem_q      <= '0;
              msg_valid  <= 1'b1;
              st_q       <= ST_SEND;
            end
            CL_MAP: begin
              msg_target <= DEST_W'(scan_idx);
              rem_q      <= scan_src & ~scan_low;
              msg_valid  <= 1'b1;
              st_q       <= ST_SEND;
            end
            default: st_q <= ST_IDLE;
          endcase
        end
        ST_SEND: begin
          if (msg_ready) begin
            if (rem_q != '0) begin
              msg_target <= DEST_W'(scan_idx);
              rem_q      <= scan_src & ~scan_low;
            end else begin
              msg_valid <= 1'b0;
              st_q      <= ST_IDLE;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_msg_dispatch_chk.sv
module irq_msg_dispatch_chk
  import irq_disp_pkg::*;
#(
  parameter int TBL_DEPTH = 24,
  parameter int LINE_W    = 5,
  parameter logic [2**MODE_W-1:0] RSVD_MODES = 8'b0100_1000
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [LINE_W-1:0] req_line,
  input logic              req_ready,
  input logic              tbl_rd_en,
  input logic [RTE_W-1:0]  tbl_rd_data,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [DEST_W-1:0] msg_target,
  input logic [VEC_W-1:0]  msg_vector,
  input logic [MODE_W-1:0] msg_dmode,
  input logic              msg_logical,
  input logic              msg_level,
  input logic              msg_trigger,
  input logic              err_o,
  input logic              busy
);
  localparam logic [LINE_W:0] DEPTH_V = (LINE_W+1)'(TBL_DEPTH);

  rte_t ent;
  logic bad;
  logic rsvd;
  logic [21:0] fld;
  assign ent  = rte_t'(tbl_rd_data);
  assign bad  = {1'b0, req_line} >= DEPTH_V;
  assign rsvd = RSVD_MODES[ent.dmode];
  assign fld  = {msg_target, msg_vector, msg_dmode, msg_logical, msg_level, msg_trigger};

  assert_reset_idle_R11: assert property (@(posedge clk)
    rst |=> !msg_valid && !err_o && !busy);

  assert_hold_stalled_R8: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready |=> msg_valid && $stable(fld));

  assert_no_intake_R9: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> !req_ready && busy);

  assert_bad_line_no_read_R6: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && bad |-> !tbl_rd_en);

  assert_bad_line_flag_R6: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && bad |=> err_o && !busy && !msg_valid);

  assert_masked_silent_R1: assert property (@(posedge clk) disable iff (rst)
    $past(tbl_rd_en) && ent.mask |=> !msg_valid && !err_o && !busy);

  assert_reserved_flag_R7: assert property (@(posedge clk) disable iff (rst)
    $past(tbl_rd_en) && !ent.mask && rsvd |=> err_o && !msg_valid);

  assert_empty_map_R10: assert property (@(posedge clk) disable iff (rst)
    $past(tbl_rd_en) && !ent.mask && !rsvd && ent.logical && ent.dest == '0
    |=> !msg_valid && req_ready);

  assert_phys_target_R3: assert property (@(posedge clk) disable iff (rst)
    $past(tbl_rd_en) && !ent.mask && !rsvd && !ent.logical
    |=> msg_valid && msg_target == $past(ent.dest) && msg_level == $past(ent.pol));
endmodule

bind irq_msg_dispatch irq_msg_dispatch_chk #(
  .TBL_DEPTH (TBL_DEPTH),
  .LINE_W    (LINE_W),
  .RSVD_MODES(RSVD_MODES)
) u_chk (.*);

// File: tb/sim_irq_msg_dispatch.sv
module sim_irq_msg_dispatch;
  import irq_disp_pkg::*;

  localparam int DEPTH  = 24;
  localparam int LINE_W = 5;
  localparam int ADDR_W = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [LINE_W-1:0] req_line = '0;
  logic req_ready, tbl_rd_en;
  logic [ADDR_W-1:0] tbl_rd_addr;
  logic [RTE_W-1:0] tbl_rd_data = '0;
  logic msg_valid, msg_ready = 1'b1;
  logic [7:0] msg_target, msg_vector;
  logic [2:0] msg_dmode;
  logic msg_logical, msg_level, msg_trigger, err_o, busy;

  always #2.5 clk = ~clk;

  irq_msg_dispatch #(.TBL_DEPTH(DEPTH), .LINE_W(LINE_W)) u0 (
    .clk, .rst, .req_valid, .req_line, .req_ready, .tbl_rd_en, .tbl_rd_addr,
    .tbl_rd_data, .msg_valid, .msg_ready, .msg_target, .msg_vector, .msg_dmode,
    .msg_logical, .msg_level, .msg_trigger, .err_o, .busy);

  // Bench-side table with one-cycle read latency
  logic [RTE_W-1:0] ram [DEPTH];
  always @(posedge clk) if (tbl_rd_en) tbl_rd_data <= ram[tbl_rd_addr];

  int checks = 0, fails = 0, cyc = 0, stall_mode = 0;
  int exp_errs = 0, seen_errs = 0;
  logic [21:0] exp_q[$];
  logic [21:0] prev_f;
  bit prev_stall = 0;
  string cur_tag = "R2";

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [RTE_W-1:0] mk(input logic [7:0] dest, input bit mask,
      input bit trig, input bit pol, input bit logical, input logic [2:0] dm,
      input logic [7:0] vec);
    return {dest, mask, trig, pol, logical, dm, vec};
  endfunction

  // Monitor: drive receiver ready, then judge the handshake of the coming edge
  always @(negedge clk) begin
    if (!rst) begin
      logic [21:0] f;
      msg_ready = (stall_mode == 0) ? 1'b1 : ((cyc % 3) == 1);
      f = {msg_target, msg_vector, msg_dmode, msg_logical, msg_level, msg_trigger};
      if (prev_stall) begin
        chk(msg_valid && f == prev_f, "R8", "stalled message changed", f, prev_f);
      end
      if (msg_valid && req_ready) chk(0, "R9", "ready while message valid", 1, 0);
      if (msg_valid && msg_ready) begin
        if (exp_q.size() == 0) chk(0, cur_tag, "unexpected message", f, 0);
        else begin
          logic [21:0] e;
          e = exp_q.pop_front();
          chk(f == e, cur_tag, "message fields", f, e);
        end
      end
      if (err_o) seen_errs++;
      prev_stall = msg_valid && !msg_ready;
      prev_f = f;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // exp_err_n: cycle after acceptance with error (0 none); exp_idle_n: idle cycle (0 skip)
  task automatic do_req(input int line, input string tag, input bit wait_done,
                        input int exp_err_n, input int exp_idle_n);
    int n, err_at, idle_at;
    cur_tag = tag;
    req_line = LINE_W'(line);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    if (line < DEPTH) begin
      logic [RTE_W-1:0] r;
      r = ram[line];
      if (!r[14] && r[10:8] != 3 && r[10:8] != 6) begin
        if (!r[11]) exp_q.push_back({r[22:15], r[7:0], r[10:8], r[11], r[12], r[13]});
        else for (int b = 0; b < 8; b++)
          if (r[15+b]) exp_q.push_back({8'(b), r[7:0], r[10:8], r[11], r[12], r[13]});
      end
    end
    if (exp_err_n != 0) exp_errs++;
    @(negedge clk);
    req_valid = 1'b0;
    if (!wait_done) return;
    n = 1; err_at = 0; idle_at = 0;
    for (int k = 0; k < 400; k++) begin
      if (err_o && err_at == 0) err_at = n;
      if (!busy && idle_at == 0) idle_at = n;
      if (!busy && exp_q.size() == 0 && n >= 2) break;
      @(negedge clk);
      n++;
    end
    chk(err_at == exp_err_n, tag, "error pulse cycle", err_at, exp_err_n);
    if (exp_idle_n > 0) chk(idle_at == exp_idle_n, tag, "idle cycle", idle_at, exp_idle_n);
    chk(exp_q.size() == 0, tag, "messages outstanding", exp_q.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) ram[i] = mk(8'h00, 1, 0, 0, 0, 3'd0, 8'h00);
    ram[2]  = mk(8'h05, 0, 0, 1, 0, 3'd0, 8'h41);
    ram[4]  = mk(8'hC3, 0, 1, 0, 0, 3'd4, 8'h9E);
    ram[3]  = mk(8'hFF, 1, 0, 0, 1, 3'd0, 8'h22);
    ram[5]  = mk(8'h10, 1, 0, 0, 0, 3'd3, 8'h23);
    ram[6]  = mk(8'hA5, 0, 1, 1, 1, 3'd1, 8'h60);
    ram[7]  = mk(8'h80, 0, 0, 0, 1, 3'd2, 8'h61);
    ram[8]  = mk(8'hFF, 0, 1, 0, 1, 3'd5, 8'h62);
    ram[9]  = mk(8'h00, 0, 0, 1, 1, 3'd0, 8'h63);
    ram[10] = mk(8'h02, 0, 0, 0, 0, 3'd6, 8'h64);
    ram[11] = mk(8'h00, 0, 1, 1, 0, 3'd7, 8'h65);
    ram[12] = mk(8'h18, 0, 0, 1, 1, 3'd0, 8'h66);
    ram[23] = mk(8'h0E, 0, 0, 0, 0, 3'd0, 8'hEE);

    repeat (3) @(negedge clk);
    chk(!msg_valid && !err_o && !busy && req_ready, "R11", "reset outputs",
        {msg_valid, err_o, busy, req_ready}, 4'b0001);
    rst = 1'b0;
    @(negedge clk);

    do_req(2,  "R3", 1, 0, 0);   // physical, single target 5, level from polarity
    do_req(4,  "R2", 1, 0, 0);   // physical, fields copied
    do_req(11, "R3", 1, 0, 0);   // physical destination zero still sends
    do_req(3,  "R1", 1, 0, 2);   // masked logical entry
    do_req(5,  "R7", 1, 0, 2);   // masked with reserved mode: silent
    do_req(6,  "R4", 1, 0, 0);   // bitmap A5 -> 0,2,5,7
    stall_mode = 1;
    do_req(6,  "R5", 1, 0, 0);   // same under receiver stalls
    do_req(7,  "R4", 1, 0, 0);   // top bit only
    do_req(8,  "R5", 1, 0, 0);   // full bitmap with stalls
    stall_mode = 0;
    do_req(9,  "R10", 1, 0, 2);  // empty bitmap
    do_req(10, "R7", 1, 2, 2);   // reserved mode 6
    do_req(24, "R6", 1, 1, 1);   // first illegal line
    do_req(31, "R6", 1, 1, 1);   // highest line code
    do_req(23, "R6", 1, 0, 0);   // last legal line works
    stall_mode = 1;
    do_req(8,  "R9", 0, 0, 0);   // expansion running...
    chk(busy && !req_ready, "R9", "busy during expansion", {busy, req_ready}, 2'b10);
    do_req(12, "R9", 1, 0, 0);   // ...second request must queue behind it
    stall_mode = 0;
    repeat (4) @(negedge clk);
    chk(seen_errs == exp_errs, "R7", "total error pulses", seen_errs, exp_errs);
    chk(!busy && req_ready && !msg_valid, "R9", "final idle",
        {busy, req_ready, msg_valid}, 3'b010);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule